// File: doc/BRIEF.md
# NAND Read Prefetch Engine

This block reads a programmed number of bytes from a NAND data port into a 64-byte internal FIFO ahead of the host. The host then takes the data as 32-bit words, four bytes per access. Software programs a configuration word, a byte count and a control word through a small register port. Setting bit 0 of the control word launches the transfer. A status word reports how many bytes are still to be fetched and how many bytes the FIFO holds.

The device side is a plain byte strobe. In each cycle `dev_rd_o` is high, the byte on `dev_data_i` is captured, and `dev_cs_o` carries the programmed chip select. Fetching pauses while the FIFO is full. The engine drops back to idle once every byte has been fetched and drained.

While the engine is busy it refuses new settings. A zero write to the control word aborts a transfer and flushes the FIFO.

Top module: `nand_prefetch_engine`

## Requirements
- R1: After reset the engine is idle: the control word reads 0, the status word reads 0, `dev_rd_o` is low and `host_ready_o` is low.
- R2: Configuration register (address 0) fields are: chip select [26:24], threshold [14:8], enable bit 7, direction bit 0. Other bits read back as 0. A write whose threshold field exceeds 64 is rejected as a whole, and the previous value is kept.
- R3: Count register (address 1) holds 14 bits of byte count. Bits 1:0 and bits above 13 of the written value are dropped, so the count is always a multiple of 4.
- R4: Writing a value with bit 0 set to the control register (address 2) starts the engine only when it is idle, enable is 1 and direction is 0. The control word then reads 1 until the engine returns to idle.
- R5: While busy, writes to the configuration and count registers, and further start writes, have no effect.
- R6: When busy, the engine asserts `dev_rd_o` and fetches one byte per cycle, starting in the cycle after the start edge. It stops while the FIFO holds 64 bytes or the remaining count is 0. `dev_cs_o` equals the configured chip select.
- R7: Status register (address 3) reports the remaining fetch count in [13:0] and the FIFO byte count in [30:24]. All other bits are 0.
- R8: `data_o` presents the four oldest FIFO bytes, packed little-endian (oldest byte in [7:0]). A `data_re_i` cycle with at least 4 bytes held removes them. With fewer than 4 bytes held, the read is ignored.
- R9: `host_ready_o` is high when the FIFO holds at least 4 bytes and either the fill level is at or above the threshold or the remaining count is 0.
- R10: The engine leaves busy at the first edge at which the remaining count and the FIFO fill are both 0.
- R11: Writing 0 to the control register clears busy, the remaining count and the FIFO at the next edge, even mid-transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 config, 1 count, 2 control, 3 status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| data_re_i | input | 1 | Host word read strobe |
| data_o | output | 32 | Oldest FIFO word, little-endian |
| host_ready_o | output | 1 | Threshold reached or last bytes held |
| dev_rd_o | output | 1 | Device byte read strobe |
| dev_cs_o | output | 3 | Device chip select |
| dev_data_i | input | 8 | Device byte, captured when `dev_rd_o` is high |

## Verification
A register write takes effect at the clock edge that samples it. After a start edge, the first `dev_rd_o` appears in the following cycle, and each strobe shows up in the status fill and remaining fields one edge later. The word on `data_o` is checked before the edge that pops it, and busy falls one edge after the FIFO has emptied with nothing left to fetch. The bench applies every stimulus for exactly one rising edge from the falling edge. It advances a cycle-accurate model of the fill level, the remaining count and the busy state across the same edge. It compares all outputs and the status and control words at the next falling edge.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {
    PF_REG_CFG  = 2'd0,
    PF_REG_CNT  = 2'd1,
    PF_REG_CTRL = 2'd2,
    PF_REG_STAT = 2'd3
  } pf_reg_e;

  localparam int CFG_CS_LSB    = 24;
  localparam int CFG_THR_LSB   = 8;
  localparam int CFG_EN_BIT    = 7;
  localparam int CFG_DIR_BIT   = 0;
  localparam int THR_W         = 7;
  localparam int THR_MAX       = 64;
  localparam int STAT_FILL_LSB = 24;
endpackage

// File: rtl/pf_regs.sv
module pf_regs
  import pf_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int CS_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [31:0]      wdata_i,
  input  logic             done_i,
  output logic [CS_W-1:0]  cs_o,
  output logic [THR_W-1:0] thr_o,
  output logic             en_o,
  output logic             dir_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             busy_o,
  output logic             start_o,
  output logic             abort_o
);
  logic cfg_hit, cnt_hit, ctrl_hit, thr_ok;

  assign cfg_hit  = we_i && (addr_i == PF_REG_CFG);
  assign cnt_hit  = we_i && (addr_i == PF_REG_CNT);
  assign ctrl_hit = we_i && (addr_i == PF_REG_CTRL);
  assign thr_ok   = wdata_i[CFG_THR_LSB +: THR_W] <= THR_W'(THR_MAX);
  assign abort_o  = ctrl_hit && (wdata_i == '0);
  assign start_o  = ctrl_hit && wdata_i[0] && !busy_o && en_o && !dir_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_o  <= '0;
      thr_o <= '0;
      en_o  <= 1'b0;
      dir_o <= 1'b0;
      cnt_o <= '0;
    end else begin
      if (cfg_hit && !busy_o && thr_ok) begin
        cs_o  <= wdata_i[CFG_CS_LSB +: CS_W];
        thr_o <= wdata_i[CFG_THR_LSB +: THR_W];
        en_o  <= wdata_i[CFG_EN_BIT];
        dir_o <= wdata_i[CFG_DIR_BIT];
      end
      if (cnt_hit && !busy_o) cnt_o <= {wdata_i[CNT_W-1:2], 2'b00};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               busy_o <= 1'b0;
    else if (abort_o)          busy_o <= 1'b0;
    else if (start_o)          busy_o <= 1'b1;
    else if (busy_o && done_i) busy_o <= 1'b0;
  end
endmodule

// File: rtl/pf_fetch.sv
module pf_fetch #(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             full_i,
  output logic             fetch_o,
  output logic [CNT_W-1:0] rem_o
);
  assign fetch_o = busy_i && (rem_o != '0) && !full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rem_o <= '0;
    else if (abort_i) rem_o <= '0;
    else if (start_i) rem_o <= cnt_i;
    else if (fetch_o) rem_o <= rem_o - 1'b1;
  end
endmodule

// File: rtl/pf_fifo.sv
module pf_fifo #(
  parameter int DEPTH = 64,
  parameter int BPW   = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int FW   = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [7:0]       byte_i,
  input  logic             pop_req_i,
  output logic [8*BPW-1:0] data_o,
  output logic [FW-1:0]    fill_o,
  output logic             full_o
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          pop;

  assign pop    = pop_req_i && (fill_o >= FW'(BPW));
  assign full_o = fill_o == FW'(DEPTH);

  for (genvar g = 0; g < BPW; g++) begin : g_lane
    assign data_o[8*g +: 8] = mem[rd_ptr + AW'(g)];
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem[wr_ptr] <= byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill_o <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill_o <= '0;
    end else begin
      if (push_i) wr_ptr <= wr_ptr + 1'b1;
      if (pop)    rd_ptr <= rd_ptr + AW'(BPW);
      fill_o <= fill_o + FW'(push_i) - (pop ? FW'(BPW) : '0);
    end
  end
endmodule

// File: rtl/nand_prefetch_engine.sv
module nand_prefetch_engine
  import pf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 14,
  parameter int CS_W  = 3,
  localparam int FW   = $clog2(DEPTH) + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [1:0]      reg_addr_i,
  input  logic [31:0]     reg_wdata_i,
  output logic [31:0]     reg_rdata_o,
  input  logic            data_re_i,
  output logic [31:0]     data_o,
  output logic            host_ready_o,
  output logic            dev_rd_o,
  output logic [CS_W-1:0] dev_cs_o,
  input  logic [7:0]      dev_data_i
);
  logic [THR_W-1:0] thr;
  logic             en, dir, busy, start, abort, full, done;
  logic [CNT_W-1:0] cnt, rem;
  logic [FW-1:0]    fill;

  pf_regs #(.CNT_W(CNT_W), .CS_W(CS_W)) regs_i (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .done_i(done), .cs_o(dev_cs_o), .thr_o(thr), .en_o(en), .dir_o(dir),
    .cnt_o(cnt), .busy_o(busy), .start_o(start), .abort_o(abort)
  );

  pf_fetch #(.CNT_W(CNT_W)) fetch_i (
    .clk_i, .rst_ni, .busy_i(busy), .start_i(start), .abort_i(abort),
    .cnt_i(cnt), .full_i(full), .fetch_o(dev_rd_o), .rem_o(rem)
  );

  pf_fifo #(.DEPTH(DEPTH), .BPW(4)) fifo_i (
    .clk_i, .rst_ni, .flush_i(abort), .push_i(dev_rd_o), .byte_i(dev_data_i),
    .pop_req_i(data_re_i), .data_o(data_o), .fill_o(fill), .full_o(full)
  );

  assign done         = (rem == '0) && (fill == '0);
  assign host_ready_o = (fill >= FW'(4)) &&
                        ((32'(fill) >= 32'(thr)) || (rem == '0));

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      PF_REG_CFG: begin
        reg_rdata_o[CFG_CS_LSB +: CS_W]   = dev_cs_o;
        reg_rdata_o[CFG_THR_LSB +: THR_W] = thr;
        reg_rdata_o[CFG_EN_BIT]           = en;
        reg_rdata_o[CFG_DIR_BIT]          = dir;
      end
      PF_REG_CNT:  reg_rdata_o[CNT_W-1:0] = cnt;
      PF_REG_CTRL: reg_rdata_o[0] = busy;
      default: begin
        reg_rdata_o[CNT_W-1:0]            = rem;
        reg_rdata_o[STAT_FILL_LSB +: FW]  = fill;
      end
    endcase
  end
endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 14,
  localparam int FW   = $clog2(DEPTH) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic [1:0]       addr_i,
  input logic [31:0]      wdata_i,
  input logic             data_re_i,
  input logic             dev_rd_i,
  input logic             busy_i,
  input logic [CNT_W-1:0] rem_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [FW-1:0]    fill_i
);
  logic abort_w;
  assign abort_w = we_i && (addr_i == 2'd2) && (wdata_i == '0);

  AST_FILL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i <= FW'(DEPTH)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !dev_rd_i); // R6
  AST_FULL_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i == FW'(DEPTH)) |-> !dev_rd_i); // R6
  AST_REM_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_rd_i && !abort_w) |=> (rem_i == $past(rem_i) - 1'b1)); // R6
  AST_ABORT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_w |=> (!busy_i && rem_i == '0 && fill_i == '0)); // R11
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && rem_i == '0 && fill_i == '0) |=> !busy_i); // R10
  AST_SHORT_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_re_i && fill_i < FW'(4) && !dev_rd_i && !abort_w) |=> $stable(fill_i)); // R8
  AST_CNT_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && we_i && addr_i == 2'd1) |=> $stable(cnt_i)); // R5
endmodule

bind nand_prefetch_engine pf_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
  .wdata_i(reg_wdata_i), .data_re_i(data_re_i), .dev_rd_i(dev_rd_o),
  .busy_i(busy), .rem_i(rem), .cnt_i(cnt), .fill_i(fill)
);

// File: tb/nand_prefetch_engine_tb_top.sv
module nand_prefetch_engine_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        data_re_i = 1'b0;
  logic [31:0] data_o;
  logic        host_ready_o, dev_rd_o;
  logic [2:0]  dev_cs_o;
  logic [7:0]  dev_data_i;

  int checks = 0;
  int errs = 0;
  bit finished = 1'b0;
  int dev_idx = 0;

  // bench model state
  bit        busy_m = 0;
  int        rem_m = 0, fill_m = 0, rd_m = 0, wr_m = 0;
  int        thr_m = 0, cnt_m = 0;
  bit [2:0]  cs_m = 0;
  bit        en_m = 0, dir_m = 0;

  always #2.5 clk_i = ~clk_i;

  nand_prefetch_engine dut_i (.*);

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 37 + 11);
  endfunction

  assign dev_data_i = pat(dev_idx);
  always @(posedge clk_i) if (dev_rd_o) dev_idx <= dev_idx + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr_i = a;
    #0.5;
    v = reg_rdata_o;
  endtask

  // one clock cycle: apply stimulus, predict, compare
  task automatic step(input bit re, input bit we, input logic [1:0] a, input logic [31:0] wd);
    bit fetch, pop, abort, start, done;
    logic [31:0] v, w;
    fetch = busy_m && rem_m != 0 && fill_m < 64;
    pop   = re && fill_m >= 4;
    chk("R6 strobe", 32'(dev_rd_o), 32'(fetch));
    if (fetch) chk("R6 cs", 32'(dev_cs_o), 32'(cs_m));
    chk("R9 ready", 32'(host_ready_o),
        32'(fill_m >= 4 && (fill_m >= thr_m || rem_m == 0)));
    if (pop) begin
      w = {pat(rd_m + 3), pat(rd_m + 2), pat(rd_m + 1), pat(rd_m)};
      chk("R8 word", data_o, w);
    end
    abort = we && a == 2'd2 && wd == 0;
    start = we && a == 2'd2 && wd[0] && !busy_m && en_m && !dir_m;
    done  = busy_m && rem_m == 0 && fill_m == 0;
    reg_we_i = we; reg_addr_i = a; reg_wdata_i = wd; data_re_i = re;
    @(negedge clk_i);
    reg_we_i = 1'b0; data_re_i = 1'b0;
    if (we && a == 2'd0 && !busy_m && wd[14:8] <= 64) begin
      cs_m = wd[26:24]; thr_m = int'(wd[14:8]); en_m = wd[7]; dir_m = wd[0];
    end
    if (we && a == 2'd1 && !busy_m) cnt_m = int'({wd[13:2], 2'b00});
    if (fetch) wr_m++;
    if (abort) begin
      busy_m = 0; rem_m = 0; fill_m = 0; rd_m = wr_m;
    end else if (start) begin
      busy_m = 1; rem_m = cnt_m;
    end else begin
      if (fetch) begin fill_m++; rem_m--; end
      if (pop) begin fill_m -= 4; rd_m += 4; end
      if (done) busy_m = 0;
    end
    rd(2'd3, v);
    chk("R7 status", v, {1'b0, 7'(fill_m), 10'd0, 14'(rem_m)});
    rd(2'd2, v);
    chk("R10 busy", v, 32'(busy_m));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 2'd0, '0);
  endtask

  task automatic drain(input int pct);
    for (int i = 0; i < 4000 && busy_m; i++)
      step(($urandom % 100) < pct, 0, 2'd0, '0);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    rd(2'd2, v); chk("R1 ctrl", v, 0);
    rd(2'd3, v); chk("R1 status", v, 0);
    chk("R1 strobe", 32'(dev_rd_o), 0);
    chk("R1 ready", 32'(host_ready_o), 0);

    // R2 config fields and threshold rejection
    step(0, 1, 2'd0, 32'h0500_10F0 | 32'h80);
    rd(2'd0, v); chk("R2 fields", v, 32'h0500_1080);
    step(0, 1, 2'd0, 32'h0200_4681);
    rd(2'd0, v); chk("R2 reject thr 70", v, 32'h0500_1080);
    step(0, 1, 2'd0, 32'h0300_4080);
    rd(2'd0, v); chk("R2 accept thr 64", v, 32'h0300_4080);

    // R3 count masking
    step(0, 1, 2'd1, 32'h0000_02A3);
    rd(2'd1, v); chk("R3 low bits", v, 32'h2A0);
    step(0, 1, 2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R3 width", v, 32'h3FFC);

    // R4 refused starts
    step(0, 1, 2'd1, 32'd64);
    step(0, 1, 2'd0, 32'h0500_1000);
    step(0, 1, 2'd2, 32'd1);
    rd(2'd2, v); chk("R4 no start en=0", v, 0);
    step(0, 1, 2'd0, 32'h0500_1081);
    step(0, 1, 2'd2, 32'd1);
    rd(2'd2, v); chk("R4 no start dir=1", v, 0);

    // R4/R9/R5 started transfer, threshold 16
    step(0, 1, 2'd0, 32'h0500_1080);
    step(0, 1, 2'd2, 32'd1);
    rd(2'd2, v); chk("R4 busy", v, 1);
    idle(8);
    rd(2'd3, v); chk("R9 fill 8", v, {8'd8, 10'd0, 14'd56});
    chk("R9 below thr", 32'(host_ready_o), 0);
    idle(8);
    chk("R9 at thr", 32'(host_ready_o), 1);
    step(0, 1, 2'd1, 32'h100);
    rd(2'd1, v); chk("R5 count locked", v, 64);
    step(0, 1, 2'd0, 32'h0100_2080);
    rd(2'd0, v); chk("R5 cfg locked", v, 32'h0500_1080);
    step(0, 1, 2'd2, 32'd1);
    drain(70);
    rd(2'd2, v); chk("R10 idle", v, 0);

    // R6 full stall with 128 bytes
    step(0, 1, 2'd1, 32'd128);
    step(0, 1, 2'd2, 32'd1);
    idle(80);
    rd(2'd3, v); chk("R6 full", v, {8'd64, 10'd0, 14'd64});
    chk("R6 stalled", 32'(dev_rd_o), 0);
    drain(100);

    // R8 short read ignored, R9 last-bytes bypass
    step(0, 1, 2'd1, 32'd8);
    step(0, 1, 2'd2, 32'd1);
    idle(2);
    step(1, 0, 2'd0, '0);
    rd(2'd3, v); chk("R8 short pop", v, {8'd3, 10'd0, 14'd5});
    idle(5);
    chk("R9 bypass", 32'(host_ready_o), 1);
    drain(100);

    // R11 abort mid-transfer
    step(0, 1, 2'd1, 32'd100);
    step(0, 1, 2'd2, 32'd1);
    idle(20);
    step(0, 1, 2'd2, 32'd0);
    rd(2'd3, v); chk("R11 status", v, 0);
    rd(2'd2, v); chk("R11 ctrl", v, 0);
    chk("R11 strobe", 32'(dev_rd_o), 0);
    idle(2);

    // random transfers
    for (int r = 0; r < 8; r++) begin
      logic [31:0] cfgw;
      cfgw = ((32'($urandom % 8)) << 24) | ((32'($urandom % 65)) << 8) | 32'h80;
      step(0, 1, 2'd0, cfgw);
      step(0, 1, 2'd1, 32'((($urandom % 60) + 1) * 4));
      step(0, 1, 2'd2, 32'd1);
      drain(20 + 10 * r);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule